// File: doc/BRIEF.md
# Two-Way Branch Target Cache

This block holds the first few instructions found at the destination of recently taken branches. When the fetch unit redirects to a target, it presents the target address on the lookup port. On a hit the cached instruction words come back combinationally in the same cycle, so the pipeline can keep issuing while the external fetch stream restarts. On a miss the fetch logic gets the instructions from external memory and streams them into the fill port one word at a time. When the final word has been written, the entry becomes usable.

The storage is 1024 bytes of 32-bit instruction words, split across two ways. A run-time mode input selects four words per entry (32 sets) or two words per entry (64 sets). Each way keeps a valid bit and an address tag for every set. One least-recently-used bit per set chooses the way that a fill replaces. An invalidate-all input empties the cache, and so does any change of the mode input.

Top module: `branch_target_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup reports a hit until an entry has been filled.
- R2: In four-word mode (`cfg_four`=1) the set is `lk_addr[8:4]`. After a completed fill of a target, a lookup of that exact address hits in the same cycle and returns fill word k on `lk_words[32k+31:32k]` for k = 0 to 3.
- R3: In two-word mode (`cfg_four`=0) the set is `lk_addr[8:3]`, giving 64 sets, and an entry takes two fill words. A hit returns them in `lk_words[63:0]` with `lk_words[127:64]` zero. Targets that differ only in address bit 3 occupy different sets.
- R4: Two targets that map to the same set with different tags are held together in the two ways, and both hit.
- R5: A hit or a completed fill marks the other way of that set as the next victim. A fill into a full set replaces the way used less recently.
- R6: An entry being filled does not hit until its last word has been written. It hits from the cycle after that write.
- R7: `fill_abort` ends a fill and leaves its entry invalid. Later `fill_valid` beats without a new `fill_start` are ignored.
- R8: `inval_all` invalidates every entry. No lookup hits in the cycle after it.
- R9: A change of `cfg_four` invalidates every entry. No lookup hits in the cycle in which the change is first seen.
- R10: `lk_hit` is low whenever `lk_valid` is low, and `lk_words` is zero whenever `lk_hit` is low.
- R11: The tag includes the word offset within the entry. A lookup of a different word of an aligned block that holds a filled target misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_four | input | 1 | 1 = four words per entry, 0 = two words per entry |
| inval_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Branch target byte address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_words | output | 128 | Cached instruction words, word 0 in the low bits |
| fill_start | input | 1 | Begin filling the entry for `fill_addr` |
| fill_addr | input | 32 | Target address of the entry being filled |
| fill_valid | input | 1 | A fill word is present |
| fill_word | input | 32 | Fill instruction word |
| fill_abort | input | 1 | Abandon the fill in progress |

## Verification
Lookups are tried on targets just filled, on the neighbouring word of the same block, and on targets that share a set. These show whether the tag comparison, the index slicing and the two ways work independently of one another. Fills are driven complete, cut short by an abort, and examined part-way through, which separates correct data from premature validity. The same addresses are tried in both entry sizes, around a mode change and around a flush. This shows that the set partitioning follows the mode and that both invalidation paths clear stale entries. A sequence of three targets in one set, with touches in a chosen order, tells an LRU victim choice apart from a fixed or a random one.

// File: rtl/btc_pkg.sv
// Package: shared types for the branch target cache.
// Assumes: nothing beyond IEEE 1800-2017.
package btc_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_t;
endpackage

// File: rtl/btc_tag_store.sv
// Module: btc_tag_store
// Holds per-way valid bits and tags plus one LRU bit per set. Compares the
// lookup tag in both ways and picks the victim way for a new fill.
// Assumes: clear and commit never target the same entry in one cycle;
// flush overrides everything else.
module btc_tag_store #(
    parameter int SETS  = 64,
    parameter int SET_W = 6,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [1:0]       lk_match,
    input  logic [SET_W-1:0] f_set,
    input  logic [TAG_W-1:0] f_tag,
    output logic             f_victim,
    input  logic             clr_en,
    input  logic             clr_way,
    input  logic [SET_W-1:0] clr_set,
    input  logic             com_en,
    input  logic             com_way,
    input  logic [SET_W-1:0] com_set,
    input  logic [TAG_W-1:0] com_tag,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic [SET_W-1:0] touch_set
);
    logic [SETS-1:0]  vld [2];
    logic [TAG_W-1:0] tag [2][SETS];
    logic [SETS-1:0]  lru;
    logic [1:0]       f_match;
    logic [1:0]       f_vld;

    for (genvar w = 0; w < 2; w++) begin : g_way
        // Valid bits: cleared by reset or flush, dropped at fill start, set at commit.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld[w] <= '0;
            end else begin
                if (clr_en && clr_way == w[0]) vld[w][clr_set] <= 1'b0;
                if (com_en && com_way == w[0]) vld[w][com_set] <= 1'b1;
            end
        end

        // Tags: written when an entry completes.
        always_ff @(posedge clk) begin
            if (com_en && com_way == w[0]) tag[w][com_set] <= com_tag;
        end

        // Compare for the lookup port and for the fill port.
        always_comb begin
            lk_match[w] = vld[w][lk_set] && (tag[w][lk_set] == lk_tag);
            f_vld[w]    = vld[w][f_set];
            f_match[w]  = f_vld[w] && (tag[w][f_set] == f_tag);
        end
    end

    // LRU: points at the way to replace next; a commit outranks a touch.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lru <= '0;
        end else begin
            if (touch_en) lru[touch_set] <= ~touch_way;
            if (com_en)   lru[com_set]   <= ~com_way;
        end
    end

    // Victim: reuse a way already holding the target, else an empty way, else LRU.
    always_comb begin
        if (f_match[0])      f_victim = 1'b0;
        else if (f_match[1]) f_victim = 1'b1;
        else if (!f_vld[0])  f_victim = 1'b0;
        else if (!f_vld[1])  f_victim = 1'b1;
        else                 f_victim = lru[f_set];
    end
endmodule

// File: rtl/btc_data_store.sv
// Module: btc_data_store
// Instruction word array, one bank per way, one write port and RD read
// ports per way with combinational read.
// Assumes: the caller forms word locations; no read-during-write bypass.
module btc_data_store #(
    parameter int WAY_WORDS = 128,
    parameter int LOC_W     = 7,
    parameter int DATA_W    = 32,
    parameter int RD        = 4
) (
    input  logic                clk,
    input  logic                we,
    input  logic                we_way,
    input  logic [LOC_W-1:0]    we_loc,
    input  logic [DATA_W-1:0]   we_data,
    input  logic [RD*LOC_W-1:0] rd_loc,
    output logic [RD*DATA_W-1:0] rd_way0,
    output logic [RD*DATA_W-1:0] rd_way1
);
    logic [DATA_W-1:0] mem0 [WAY_WORDS];
    logic [DATA_W-1:0] mem1 [WAY_WORDS];

    // Write port: one word per cycle into the selected way.
    always_ff @(posedge clk) begin
        if (we && !we_way) mem0[we_loc] <= we_data;
        if (we &&  we_way) mem1[we_loc] <= we_data;
    end

    for (genvar k = 0; k < RD; k++) begin : g_rd
        // Read port k: same location in both ways.
        always_comb begin
            rd_way0[k*DATA_W +: DATA_W] = mem0[rd_loc[k*LOC_W +: LOC_W]];
            rd_way1[k*DATA_W +: DATA_W] = mem1[rd_loc[k*LOC_W +: LOC_W]];
        end
    end
endmodule

// File: rtl/btc_fill_ctrl.sv
// Module: btc_fill_ctrl
// Sequences a fill: claims the victim entry at start, writes words in order
// and commits the entry after the last one. Abort or flush drops the fill.
// Assumes: priority flush > start > abort > data beat.
module btc_fill_ctrl
    import btc_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             four,
    input  logic             start,
    input  logic [SET_W-1:0] s_set,
    input  logic [TAG_W-1:0] s_tag,
    input  logic             s_way,
    input  logic             beat,
    input  logic             abort,
    output logic             busy,
    output logic             clr_en,
    output logic             wr_en,
    output logic             cur_way,
    output logic [SET_W-1:0] cur_set,
    output logic [TAG_W-1:0] cur_tag,
    output logic [1:0]       cur_idx,
    output logic             com_en
);
    fill_state_t st_q;
    logic        last;

    assign busy   = (st_q == FS_FILL);
    assign clr_en = start && !flush;
    assign wr_en  = busy && beat && !start && !abort && !flush;
    assign last   = (cur_idx == (four ? 2'd3 : 2'd1));
    assign com_en = wr_en && last;

    // Fill sequencing: capture the entry at start, count words, stop at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            st_q    <= FS_IDLE;
            cur_idx <= '0;
        end else if (start) begin
            st_q    <= FS_FILL;
            cur_idx <= '0;
        end else if (abort) begin
            st_q    <= FS_IDLE;
        end else if (wr_en) begin
            if (last) st_q <= FS_IDLE;
            cur_idx <= cur_idx + 2'd1;
        end
    end

    // Entry identity held for the duration of the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_way <= 1'b0;
            cur_set <= '0;
            cur_tag <= '0;
        end else if (clr_en) begin
            cur_way <= s_way;
            cur_set <= s_set;
            cur_tag <= s_tag;
        end
    end
endmodule

// File: rtl/branch_target_cache.sv
// Module: branch_target_cache
// Two-way branch target cache with 1024 bytes of instruction storage,
// two or four words per entry selected at run time. A hit returns the
// target words combinationally; misses are filled word by word.
// Assumes: cfg_four changes are rare; any change flushes the cache.
module branch_target_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTES  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_four,
    input  logic              inval_all,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [4*DATA_W-1:0] lk_words,
    input  logic              fill_start,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_word,
    input  logic              fill_abort
);
    localparam int WORDS     = BYTES / (DATA_W / 8);
    localparam int WAY_WORDS = WORDS / 2;
    localparam int LOC_W     = $clog2(WAY_WORDS);
    localparam int SET_W     = LOC_W - 1;
    localparam int SETS      = 1 << SET_W;
    localparam int HI_LSB    = LOC_W + 2;
    localparam int TAG_W     = ADDR_W - HI_LSB + 2;
    localparam int RD        = 4;

    logic              mode_q;
    logic              flush;
    logic              mode_ok;
    logic [SET_W-1:0]  lk_set, f_set;
    logic [TAG_W-1:0]  lk_tag, f_tag;
    logic [1:0]        lk_match;
    logic              f_victim;
    logic              fc_busy, fc_clr, fc_wr, fc_com, fc_way;
    logic [SET_W-1:0]  fc_set;
    logic [TAG_W-1:0]  fc_tag;
    logic [1:0]        fc_idx;
    logic [LOC_W-1:0]  wr_loc;
    logic [RD*LOC_W-1:0] rd_loc;
    logic [RD*DATA_W-1:0] rd_w0, rd_w1;
    logic [3:0]        unused_bits;

    assign unused_bits = {lk_addr[1:0], fill_addr[1:0]};

    // Index of an address: bits above the entry offset.
    function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a, input logic four);
        set_of = four ? {1'b0, a[LOC_W+1:4]} : a[LOC_W+1:3];
    endfunction

    // Tag of an address: high bits plus the word offset inside the entry.
    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a, input logic four);
        tag_of = {a[ADDR_W-1:HI_LSB], (four ? a[3:2] : {1'b0, a[2]})};
    endfunction

    // Word location in a way for word k of an entry.
    function automatic logic [LOC_W-1:0] loc_of(input logic [SET_W-1:0] s, input logic [1:0] k,
                                                 input logic four);
        loc_of = four ? {s[SET_W-2:0], k} : {s, k[0]};
    endfunction

    // Mode tracker: a change of mode flushes the cache.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= cfg_four;
        else        mode_q <= cfg_four;
    end

    assign mode_ok = (cfg_four == mode_q);
    assign flush   = inval_all || !mode_ok;
    assign lk_set  = set_of(lk_addr, cfg_four);
    assign lk_tag  = tag_of(lk_addr, cfg_four);
    assign f_set   = set_of(fill_addr, cfg_four);
    assign f_tag   = tag_of(fill_addr, cfg_four);
    assign wr_loc  = loc_of(fc_set, fc_idx, cfg_four);

    for (genvar k = 0; k < RD; k++) begin : g_loc
        assign rd_loc[k*LOC_W +: LOC_W] = loc_of(lk_set, k[1:0], cfg_four);
    end

    btc_tag_store #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_set   (lk_set),
        .lk_tag   (lk_tag),
        .lk_match (lk_match),
        .f_set    (f_set),
        .f_tag    (f_tag),
        .f_victim (f_victim),
        .clr_en   (fc_clr),
        .clr_way  (f_victim),
        .clr_set  (f_set),
        .com_en   (fc_com),
        .com_way  (fc_way),
        .com_set  (fc_set),
        .com_tag  (fc_tag),
        .touch_en (lk_hit),
        .touch_way(lk_match[1]),
        .touch_set(lk_set)
    );

    btc_fill_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .four   (cfg_four),
        .start  (fill_start),
        .s_set  (f_set),
        .s_tag  (f_tag),
        .s_way  (f_victim),
        .beat   (fill_valid),
        .abort  (fill_abort),
        .busy   (fc_busy),
        .clr_en (fc_clr),
        .wr_en  (fc_wr),
        .cur_way(fc_way),
        .cur_set(fc_set),
        .cur_tag(fc_tag),
        .cur_idx(fc_idx),
        .com_en (fc_com)
    );

    btc_data_store #(.WAY_WORDS(WAY_WORDS), .LOC_W(LOC_W), .DATA_W(DATA_W), .RD(RD)) u_data (
        .clk    (clk),
        .we     (fc_wr),
        .we_way (fc_way),
        .we_loc (wr_loc),
        .we_data(fill_word),
        .rd_loc (rd_loc),
        .rd_way0(rd_w0),
        .rd_way1(rd_w1)
    );

    // Hit and word selection; words beyond the entry size read as zero.
    always_comb begin
        lk_hit   = lk_valid && mode_ok && (lk_match != 2'b00);
        lk_words = '0;
        if (lk_hit) begin
            lk_words = lk_match[1] ? rd_w1 : rd_w0;
            if (!cfg_four) lk_words[4*DATA_W-1:2*DATA_W] = '0;
        end
    end
endmodule

// File: rtl/btc_checker.sv
// Module: btc_checker
// Temporal properties of the branch target cache, bound to its top.
// Assumes: inputs are driven to known values from time zero.
module btc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_four,
    input logic       inval_all,
    input logic       lk_valid,
    input logic       lk_hit,
    input logic [1:0] match,
    input logic       busy,
    input logic       fill_start,
    input logic       fill_abort
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit); // R1
    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R4
    AST_ABORT_ENDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_abort && !fill_start) |=> !busy); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !lk_hit); // R8
    AST_MODE_SWAP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_four != $past(cfg_four)) |-> !lk_hit); // R9
    AST_STROBE_GATES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit); // R10
endmodule

bind branch_target_cache btc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_four  (cfg_four),
    .inval_all (inval_all),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .match     (lk_match),
    .busy      (fc_busy),
    .fill_start(fill_start),
    .fill_abort(fill_abort)
);

// File: tb/sim_branch_target_cache.sv
module sim_branch_target_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_four = 1'b1;
    logic         inval_all = 1'b0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_hit;
    logic [127:0] lk_words;
    logic         fill_start = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_word = '0;
    logic         fill_abort = 1'b0;
    int           checks = 0;
    int           errors = 0;

    always #5 clk = ~clk;

    branch_target_cache u0 (.*);

    function automatic logic [31:0] dat(input logic [31:0] a, input int k);
        return a * 32'd7 + 32'(k) * 32'h0101_0000 + 32'h1234_0000;
    endfunction

    function automatic logic [127:0] blk(input logic [31:0] a, input int n);
        logic [127:0] r = '0;
        for (int k = 0; k < n; k++) r[32*k +: 32] = dat(a, k);
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup at a negedge, sample 1 ns later, release at the next negedge.
    task automatic look(input string req, input logic [31:0] a, input logic eh, input logic [127:0] ew);
        lk_valid = 1'b1; lk_addr = a;
        #1;
        check(req, {127'd0, lk_hit}, {127'd0, eh});
        check(req, lk_words, ew);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic start_fill(input logic [31:0] a);
        fill_start = 1'b1; fill_addr = a;
        @(negedge clk);
        fill_start = 1'b0;
    endtask

    task automatic beats(input logic [31:0] a, input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            fill_valid = 1'b1; fill_word = dat(a, k);
            @(negedge clk);
        end
        fill_valid = 1'b0;
    endtask

    task automatic fill(input logic [31:0] a, input int n);
        start_fill(a);
        beats(a, 0, n);
    endtask

    task automatic t_reset;
        look("R1", 32'h0000_1000, 1'b0, '0);
        look("R1", 32'h0000_0000, 1'b0, '0);
    endtask

    task automatic t_four;
        fill(32'h0000_1000, 4);
        look("R2", 32'h0000_1000, 1'b1, blk(32'h0000_1000, 4));
        look("R11", 32'h0000_1004, 1'b0, '0);
        lk_addr = 32'h0000_1000; lk_valid = 1'b0;
        #1;
        check("R10", {127'd0, lk_hit}, '0);
        check("R10", lk_words, '0);
        @(negedge clk);
    endtask

    task automatic t_partial;
        start_fill(32'h0000_1010);
        beats(32'h0000_1010, 0, 3);
        look("R6", 32'h0000_1010, 1'b0, '0);
        beats(32'h0000_1010, 3, 4);
        look("R6", 32'h0000_1010, 1'b1, blk(32'h0000_1010, 4));
    endtask

    task automatic t_abort;
        start_fill(32'h0000_1020);
        beats(32'h0000_1020, 0, 2);
        fill_abort = 1'b1;
        @(negedge clk);
        fill_abort = 1'b0;
        beats(32'h0000_1020, 2, 4);
        look("R7", 32'h0000_1020, 1'b0, '0);
    endtask

    task automatic t_lru;
        fill(32'h0000_1030, 4);
        fill(32'h0000_2030, 4);
        look("R4", 32'h0000_2030, 1'b1, blk(32'h0000_2030, 4));
        look("R4", 32'h0000_1030, 1'b1, blk(32'h0000_1030, 4));
        fill(32'h0000_3030, 4);
        look("R5", 32'h0000_2030, 1'b0, '0);
        look("R5", 32'h0000_1030, 1'b1, blk(32'h0000_1030, 4));
        look("R5", 32'h0000_3030, 1'b1, blk(32'h0000_3030, 4));
    endtask

    task automatic t_flush;
        fill(32'h0000_1040, 4);
        look("R8", 32'h0000_1040, 1'b1, blk(32'h0000_1040, 4));
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        look("R8", 32'h0000_1040, 1'b0, '0);
        look("R8", 32'h0000_1000, 1'b0, '0);
    endtask

    task automatic t_two;
        fill(32'h0000_1000, 4);
        cfg_four = 1'b0;
        look("R9", 32'h0000_1000, 1'b0, '0);
        look("R9", 32'h0000_1000, 1'b0, '0);
        fill(32'h0000_5000, 2);
        fill(32'h0000_5008, 2);
        fill(32'h0000_6000, 2);
        look("R3", 32'h0000_5000, 1'b1, blk(32'h0000_5000, 2));
        look("R3", 32'h0000_5008, 1'b1, blk(32'h0000_5008, 2));
        look("R3", 32'h0000_6000, 1'b1, blk(32'h0000_6000, 2));
        cfg_four = 1'b1;
        @(negedge clk);
        look("R9", 32'h0000_5000, 1'b0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four();
        t_partial();
        t_abort();
        t_lru();
        t_flush();
        t_two();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule